// File: doc/BRIEF.md
# Multi-Format Pixel Stream Formatter

This block turns a stream of 32-bit words into parallel 24-bit RGB pixels. It generates its own horizontal and vertical sync and its own data-enable. The words arrive over a valid/ready handshake. A format input selects how each word is split into pixels:

- **Palette mode:** four 8-bit colour indices per word, each looked up in an internal 256-entry colour table.
- **565 mode:** two 16-bit pixels per word, each widened to 8 bits per channel.
- **RGBX mode:** one pixel per word.

A raster generator counts pixels and lines. Each axis has four lengths set at run time: visible, front porch, sync and back porch. The block consumes one pixel on each visible clock. It accepts a new word only when the last pixel of the current word has been used.

The colour table is loaded through a plain write port. Sync and data-enable are delayed to match the one-clock table read. If no word is available when a pixel is due, that pixel is shown black and a sticky flag records the shortfall. The format is captured once per frame, so changing the input mid-frame never mixes formats within a frame.

Top module: `stream_pixel_formatter`

## Requirements
- R1: Each line runs visible, then front porch, then sync, then back porch pixels, and each frame runs the same four segments in lines. `de_o` is high exactly when both the pixel and the line position lie in their visible segments.
- R2: `hsync_o` is at its asserted level during the horizontal sync segment, and `vsync_o` during the lines of the vertical sync segment. The asserted level equals `hs_pol_i` / `vs_pol_i` (1 = active high), and the opposite level is driven elsewhere.
- R3: Format code 2 (RGBX): one pixel per word, with red = bits 7:0, green = bits 15:8 and blue = bits 23:16. Bits 31:24 are ignored. `rgb_o` carries red in bits 23:16, green in 15:8 and blue in 7:0.
- R4: Format code 1 (565): the 16-bit field in bits 15:0 is shown first, then bits 31:16. Each field holds red in 15:11, green in 10:5 and blue in 4:0. Each channel is widened by repeating its top bits: red {r,r[4:2]}, green {g,g[5:4]}, blue {b,b[4:2]}.
- R5: Format code 0 (palette): the four bytes are shown from bits 7:0 upward. Each byte indexes the colour table, which is written through `pal_we_i`/`pal_addr_i`/`pal_data_i`.
- R6: `s_tready_o` is high only in a visible cycle with `s_tvalid_i` high in which the last pixel of the word is used. A frame of N visible pixels therefore takes N/4, N/2 or N words in the three formats.
- R7: Outside the visible region `rgb_o` is zero, no word is accepted and the underflow flag is not set.
- R8: A visible pixel with `s_tvalid_i` low is shown black. `underflow_o` goes high in the next cycle and stays high.
- R9: `underflow_clr_i` clears `underflow_o` in the next cycle. A new shortfall in the same cycle wins over the clear.
- R10: `mode_i` is sampled only in the first pixel cycle of a frame. A change at any other time affects only the following frame.
- R11: `rgb_o`, `de_o`, `hsync_o` and `vsync_o` all follow the raster position by one clock and stay aligned in every format.
- R12: During reset `de_o` and `rgb_o` are zero, `underflow_o` is low and both syncs are at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Format: 0 palette, 1 565, 2 RGBX (3 acts as RGBX) |
| h_active_i | input | LEN_W | Visible pixels per line |
| h_front_i | input | LEN_W | Horizontal front porch length |
| h_sync_i | input | LEN_W | Horizontal sync length |
| h_back_i | input | LEN_W | Horizontal back porch length |
| v_active_i | input | LEN_W | Visible lines per frame |
| v_front_i | input | LEN_W | Vertical front porch lines |
| v_sync_i | input | LEN_W | Vertical sync lines |
| v_back_i | input | LEN_W | Vertical back porch lines |
| hs_pol_i | input | 1 | Asserted level of hsync |
| vs_pol_i | input | 1 | Asserted level of vsync |
| pal_we_i | input | 1 | Colour table write enable |
| pal_addr_i | input | 8 | Colour table write address |
| pal_data_i | input | 24 | Colour table write data |
| s_tdata_i | input | 32 | Stream word |
| s_tvalid_i | input | 1 | Stream word valid |
| s_tready_o | output | 1 | Stream word accepted |
| underflow_clr_i | input | 1 | Clears the underflow flag |
| rgb_o | output | 24 | Pixel colour, red in the top byte |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Visible-pixel enable |
| underflow_o | output | 1 | Sticky missing-word flag |

## Verification
Pixel, enable and sync results for raster position p appear one clock after p, so the bench samples them at the falling edge after clock p+1. It compares them against a raster model of its own that runs one position behind. A word handshake takes effect at the rising edge where `s_tready_o` and `s_tvalid_i` are both high. The bench reads `s_tready_o` shortly after it drives the word, then counts accepted words per frame.

Flag results (set and clear of `underflow_o`) are checked exactly one clock after the pixel or clear that causes them. Mode changes are made at frame position 20, mid-frame, so every frame also tests that the format is held.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;
  localparam int WORD_W = 32;
  localparam int RGB_W  = 24;
  localparam int IDX_W  = 8;
  localparam int SLOT_W = 2;

  typedef enum logic [1:0] {
    FMT_PAL  = 2'd0,
    FMT_565  = 2'd1,
    FMT_RGBX = 2'd2,
    FMT_RSVD = 2'd3
  } fmt_e;

  // index of the final pixel slot inside one word
  function automatic logic [SLOT_W-1:0] last_slot(fmt_e f);
    case (f)
      FMT_PAL: last_slot = 2'd3;
      FMT_565: last_slot = 2'd1;
      default: last_slot = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/pixfmt_raster.sv
module pixfmt_raster #(
  parameter int LEN_W = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [1:0][3:0][LEN_W-1:0]   len_i,   // [axis][visible,front,sync,back]
  output logic                         active_o,
  output logic                         hsync_o,
  output logic                         vsync_o,
  output logic                         frame_start_o
);
  localparam int POS_W = LEN_W + 2;

  logic [POS_W-1:0] pos_q [2];
  logic [1:0] in_act, in_sync, at_end;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    logic [POS_W-1:0] sync_lo, sync_hi, last_pos;
    assign sync_lo  = POS_W'(len_i[a][0]) + POS_W'(len_i[a][1]);
    assign sync_hi  = sync_lo + POS_W'(len_i[a][2]);
    assign last_pos = sync_hi + POS_W'(len_i[a][3]) - POS_W'(1);
    assign in_act[a]  = pos_q[a] < POS_W'(len_i[a][0]);
    assign in_sync[a] = (pos_q[a] >= sync_lo) && (pos_q[a] < sync_hi);
    // >= lets a shortened length recover without a full counter wrap
    assign at_end[a]  = pos_q[a] >= last_pos;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q[0] <= '0;
      pos_q[1] <= '0;
    end else if (at_end[0]) begin
      pos_q[0] <= '0;
      pos_q[1] <= at_end[1] ? '0 : pos_q[1] + POS_W'(1);
    end else begin
      pos_q[0] <= pos_q[0] + POS_W'(1);
    end
  end

  assign active_o      = in_act[0] & in_act[1];
  assign hsync_o       = in_sync[0];
  assign vsync_o       = in_sync[1];
  assign frame_start_o = (pos_q[0] == '0) && (pos_q[1] == '0);
endmodule

// File: rtl/pixfmt_palette.sv
module pixfmt_palette #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/pixfmt_unpack.sv
module pixfmt_unpack
  import pixfmt_pkg::*;
(
  input  fmt_e              fmt_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [RGB_W-1:0]  rgb_o
);
  logic [15:0]      half;
  logic [RGB_W-1:0] wide565, rgbx;

  always_comb begin
    idx_o   = word_i[{slot_i, 3'b000} +: IDX_W];
    half    = slot_i[0] ? word_i[31:16] : word_i[15:0];
    wide565 = {half[15:11], half[15:13], half[10:5], half[10:9], half[4:0], half[4:2]};
    rgbx    = {word_i[7:0], word_i[15:8], word_i[23:16]};
    rgb_o   = (fmt_i == FMT_565) ? wide565 : rgbx;
  end
endmodule

// File: rtl/stream_pixel_formatter.sv
module stream_pixel_formatter
  import pixfmt_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [LEN_W-1:0]  h_active_i,
  input  logic [LEN_W-1:0]  h_front_i,
  input  logic [LEN_W-1:0]  h_sync_i,
  input  logic [LEN_W-1:0]  h_back_i,
  input  logic [LEN_W-1:0]  v_active_i,
  input  logic [LEN_W-1:0]  v_front_i,
  input  logic [LEN_W-1:0]  v_sync_i,
  input  logic [LEN_W-1:0]  v_back_i,
  input  logic              hs_pol_i,
  input  logic              vs_pol_i,
  input  logic              pal_we_i,
  input  logic [7:0]        pal_addr_i,
  input  logic [23:0]       pal_data_i,
  input  logic [31:0]       s_tdata_i,
  input  logic              s_tvalid_i,
  output logic              s_tready_o,
  input  logic              underflow_clr_i,
  output logic [23:0]       rgb_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              underflow_o
);
  logic [1:0][3:0][LEN_W-1:0] lens;
  assign lens[0] = {h_back_i, h_sync_i, h_front_i, h_active_i};
  assign lens[1] = {v_back_i, v_sync_i, v_front_i, v_active_i};

  logic active, in_hs, in_vs, frame_start;

  pixfmt_raster #(.LEN_W(LEN_W)) i_raster (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .len_i         (lens),
    .active_o      (active),
    .hsync_o       (in_hs),
    .vsync_o       (in_vs),
    .frame_start_o (frame_start)
  );

  // format and slot are frozen/reset at the first pixel of each frame
  fmt_e              mode_q, mode_now;
  logic [SLOT_W-1:0] slot_q, slot_cur, slot_d;
  logic              take, word_done;

  assign mode_now  = frame_start ? fmt_e'(mode_i) : mode_q;
  assign slot_cur  = frame_start ? '0 : slot_q;
  assign take      = active & s_tvalid_i;
  assign word_done = take && (slot_cur == last_slot(mode_now));
  assign s_tready_o = word_done;

  always_comb begin
    slot_d = slot_cur;
    if (take) slot_d = word_done ? '0 : slot_cur + SLOT_W'(1);
  end

  logic [IDX_W-1:0] pal_idx;
  logic [RGB_W-1:0] direct_rgb, pal_rgb;

  pixfmt_unpack i_unpack (
    .fmt_i  (mode_now),
    .word_i (s_tdata_i),
    .slot_i (slot_cur),
    .idx_o  (pal_idx),
    .rgb_o  (direct_rgb)
  );

  pixfmt_palette #(.ADDR_W(IDX_W), .DATA_W(RGB_W)) i_palette (
    .clk_i   (clk_i),
    .we_i    (pal_we_i),
    .waddr_i (pal_addr_i),
    .wdata_i (pal_data_i),
    .raddr_i (pal_idx),
    .rdata_o (pal_rgb)
  );

  logic             de_q, hs_q, vs_q, use_pal_q, have_q, underflow_q;
  logic [RGB_W-1:0] direct_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= FMT_PAL;
      slot_q      <= '0;
      underflow_q <= 1'b0;
      de_q        <= 1'b0;
      hs_q        <= 1'b0;
      vs_q        <= 1'b0;
      use_pal_q   <= 1'b0;
      have_q      <= 1'b0;
      direct_q    <= '0;
    end else begin
      mode_q    <= mode_now;
      slot_q    <= slot_d;
      // a fresh shortfall beats the clear
      if (active && !s_tvalid_i) underflow_q <= 1'b1;
      else if (underflow_clr_i)  underflow_q <= 1'b0;
      de_q      <= active;
      hs_q      <= in_hs;
      vs_q      <= in_vs;
      use_pal_q <= (mode_now == FMT_PAL);
      have_q    <= take;
      direct_q  <= direct_rgb;
    end
  end

  assign rgb_o       = (de_q && have_q) ? (use_pal_q ? pal_rgb : direct_q) : '0;
  assign de_o        = de_q;
  assign hsync_o     = hs_q ? hs_pol_i : ~hs_pol_i;
  assign vsync_o     = vs_q ? vs_pol_i : ~vs_pol_i;
  assign underflow_o = underflow_q;
endmodule

// File: rtl/pixfmt_checker.sv
module pixfmt_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        s_tvalid_i,
  input logic        s_tready_o,
  input logic        underflow_clr_i,
  input logic        underflow_o,
  input logic        de_o,
  input logic [23:0] rgb_o,
  input logic        hsync_o,
  input logic        vsync_o,
  input logic        hs_pol_i,
  input logic        vs_pol_i,
  input logic        frame_start,
  input logic [1:0]  mode_q
);
  a_r6_ready_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_tready_o |-> s_tvalid_i);

  a_r7_black_when_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> (rgb_o == '0));

  a_r2_no_sync_in_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> ((hsync_o != hs_pol_i) && (vsync_o != vs_pol_i)));

  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !underflow_clr_i) |=> underflow_o);

  a_r8_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underflow_o) |-> !$past(s_tvalid_i));

  a_r9_clear_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_clr_i && s_tvalid_i) |=> !underflow_o);

  a_r10_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start |=> $stable(mode_q));
endmodule

bind stream_pixel_formatter pixfmt_checker i_pixfmt_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .s_tvalid_i      (s_tvalid_i),
  .s_tready_o      (s_tready_o),
  .underflow_clr_i (underflow_clr_i),
  .underflow_o     (underflow_o),
  .de_o            (de_o),
  .rgb_o           (rgb_o),
  .hsync_o         (hsync_o),
  .vsync_o         (vsync_o),
  .hs_pol_i        (hs_pol_i),
  .vs_pol_i        (vs_pol_i),
  .frame_start     (frame_start),
  .mode_q          (mode_q)
);

// File: tb/test_stream_pixel_formatter.sv
`timescale 1ns/1ps
module test_stream_pixel_formatter;
  localparam int LEN_W = 12;
  localparam int HA = 8, HF = 2, HS = 3, HB = 2, HT = HA + HF + HS + HB;
  localparam int VA = 3, VF = 1, VS = 1, VB = 1, VT = VA + VF + VS + VB;
  localparam int FT = HT * VT;

  typedef struct packed {
    logic [1:0] mode;
    logic       valid;
    logic [7:0] n_words;
    logic       uf_end;
  } phase_t;

  // per-frame stimulus and expected results
  localparam phase_t PHASES [5] = '{
    '{2'd2, 1'b1, 8'd24, 1'b0},   // RGBX
    '{2'd1, 1'b1, 8'd12, 1'b0},   // 565
    '{2'd0, 1'b1, 8'd6,  1'b0},   // palette
    '{2'd2, 1'b0, 8'd0,  1'b1},   // starved frame
    '{2'd2, 1'b0, 8'd0,  1'b0}    // starved, flag cleared in blanking
  };

  logic clk = 1'b0;
  logic rst_ni;
  logic [1:0] mode_i;
  logic hs_pol, vs_pol, pal_we, s_tvalid, s_tready, uf_clr;
  logic [7:0] pal_addr;
  logic [23:0] pal_data, rgb;
  logic [31:0] s_tdata;
  logic hsync, vsync, de, underflow;

  always #2 clk = ~clk;

  stream_pixel_formatter #(.LEN_W(LEN_W)) i_stream_pixel_formatter (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i),
    .h_active_i(LEN_W'(HA)), .h_front_i(LEN_W'(HF)), .h_sync_i(LEN_W'(HS)), .h_back_i(LEN_W'(HB)),
    .v_active_i(LEN_W'(VA)), .v_front_i(LEN_W'(VF)), .v_sync_i(LEN_W'(VS)), .v_back_i(LEN_W'(VB)),
    .hs_pol_i(hs_pol), .vs_pol_i(vs_pol),
    .pal_we_i(pal_we), .pal_addr_i(pal_addr), .pal_data_i(pal_data),
    .s_tdata_i(s_tdata), .s_tvalid_i(s_tvalid), .s_tready_o(s_tready),
    .underflow_clr_i(uf_clr),
    .rgb_o(rgb), .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .underflow_o(underflow)
  );

  int n_chk = 0, n_fail = 0;
  bit summary_done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  function automatic logic [23:0] pal_col(input int i);
    return {8'(i), 8'(i * 3), 8'(~i)};
  endfunction

  function automatic logic [31:0] word_of(input int ph, input int i);
    if (i == 0) return 32'hFFFF_0000;
    return 32'h6B3D_91C5 ^ (32'(i) * 32'h0103_0507) ^ (32'(ph) << 27);
  endfunction

  function automatic logic [23:0] exp_pix(input logic [1:0] m, input logic [31:0] w, input int j);
    logic [15:0] h;
    logic [4:0] r, b;
    logic [5:0] g;
    case (m)
      2'd0: return pal_col(int'(w[8*j +: 8]));
      2'd1: begin
        h = w[16*j +: 16];
        r = h[15:11]; g = h[10:5]; b = h[4:0];
        return {r, r[4:2], g, g[5:4], b, b[4:2]};
      end
      default: return {w[7:0], w[15:8], w[23:16]};
    endcase
  endfunction

  function automatic int ppw(input logic [1:0] m);
    return (m == 2'd0) ? 4 : (m == 2'd1) ? 2 : 1;
  endfunction

  logic [1:0] exp_mode;
  int phase_now, k;
  bit valid_prev;

  // compares outputs for raster position pos (one clock behind the counters)
  task automatic mon(input int pos);
    int fp, h, v;
    bit de_e, hs_in, vs_in;
    logic [23:0] e;
    string tag;
    fp = pos % FT; h = fp % HT; v = fp / HT;
    de_e  = (h < HA) && (v < VA);
    hs_in = (h >= HA + HF) && (h < HA + HF + HS);
    vs_in = (v >= VA + VF) && (v < VA + VF + VS);
    chk(de == de_e, "R1 R11 de", 32'(de), 32'(de_e));
    chk(hsync == (hs_in ? hs_pol : !hs_pol), "R2 hsync", 32'(hsync), 32'(hs_in ? hs_pol : !hs_pol));
    chk(vsync == (vs_in ? vs_pol : !vs_pol), "R2 vsync", 32'(vsync), 32'(vs_in ? vs_pol : !vs_pol));
    if (de_e) begin
      if (valid_prev) begin
        e = exp_pix(exp_mode, word_of(phase_now, k / ppw(exp_mode)), k % ppw(exp_mode));
        tag = (exp_mode == 2'd0) ? "R5 R10 palette pixel" :
              (exp_mode == 2'd1) ? "R4 R10 565 pixel" : "R3 R10 rgbx pixel";
        chk(rgb == e, tag, 32'(rgb), 32'(e));
        k++;
      end else begin
        chk(rgb == 24'h0, "R8 black on shortfall", 32'(rgb), 32'h0);
      end
    end else begin
      chk(rgb == 24'h0, "R7 black outside visible", 32'(rgb), 32'h0);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!summary_done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 5000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int ptr, n_words;
    bit hs_flag, cur_valid, valid_pos;
    rst_ni = 1'b0; mode_i = PHASES[0].mode; hs_pol = 1'b1; vs_pol = 1'b0;
    pal_we = 1'b0; pal_addr = '0; pal_data = '0; s_tvalid = 1'b0; s_tdata = '0; uf_clr = 1'b0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      pal_we = 1'b1; pal_addr = 8'(i); pal_data = pal_col(i);
    end
    @(negedge clk);
    pal_we = 1'b0;
    // R12 reset state
    chk(de == 1'b0, "R12 de in reset", 32'(de), 32'h0);
    chk(rgb == 24'h0, "R12 rgb in reset", 32'(rgb), 32'h0);
    chk(underflow == 1'b0, "R12 flag in reset", 32'(underflow), 32'h0);
    chk(hsync == !hs_pol, "R12 hsync inactive", 32'(hsync), 32'(!hs_pol));
    chk(vsync == !vs_pol, "R12 vsync inactive", 32'(vsync), 32'(!vs_pol));
    chk(s_tready == 1'b0, "R12 R6 ready in reset", 32'(s_tready), 32'h0);
    rst_ni = 1'b1;

    ptr = 0; k = 0; n_words = 0; hs_flag = 0; cur_valid = 0; valid_prev = 0;
    exp_mode = PHASES[0].mode; phase_now = 0;
    for (int p = 0; p < 5; p++) begin
      for (int c = 0; c < FT; c++) begin
        if (p > 0 || c > 0) mon(p * FT + c - 1);
        if (hs_flag) ptr++;
        if (c == 0) begin
          ptr = 0; k = 0; n_words = 0;
          exp_mode = PHASES[p].mode; phase_now = p; cur_valid = PHASES[p].valid;
          if (p == 4) begin hs_pol = 1'b0; vs_pol = 1'b1; end
        end
        // mid-frame change: must only take effect at the next frame (R10)
        if (c == 20 && p < 4) mode_i = PHASES[p + 1].mode;
        if (p == 3 && c == 0) chk(underflow == 1'b0, "R8 flag before shortfall", 32'(underflow), 32'h0);
        if (p == 3 && c == 1) chk(underflow == 1'b1, "R8 flag one clock after", 32'(underflow), 32'h1);
        if (p == 4 && c == 5) uf_clr = 1'b1;
        if (p == 4 && c == 6) begin
          chk(underflow == 1'b1, "R9 shortfall beats clear", 32'(underflow), 32'h1);
          uf_clr = 1'b0;
        end
        if (p == 4 && c == 50) uf_clr = 1'b1;
        if (p == 4 && c == 51) begin
          chk(underflow == 1'b0, "R9 clear in blanking", 32'(underflow), 32'h0);
          uf_clr = 1'b0;
        end
        if (p == 4 && c > 51) chk(underflow == 1'b0, "R7 no flag in blanking", 32'(underflow), 32'h0);
        s_tvalid = cur_valid;
        s_tdata  = word_of(p, ptr);
        valid_pos = cur_valid;
        #1;
        hs_flag = s_tvalid && s_tready;
        if (hs_flag) n_words++;
        @(posedge clk);
        @(negedge clk);
        valid_prev = valid_pos;
      end
      chk(n_words == int'(PHASES[p].n_words), "R6 words per frame", 32'(n_words), 32'(PHASES[p].n_words));
      chk(underflow == PHASES[p].uf_end, "R8 flag at frame end", 32'(underflow), 32'(PHASES[p].uf_end));
    end
    summary();
    $finish;
  end
endmodule